// File: doc/BRIEF.md
# Tiled Texture Address Generator

This block turns a microtile coordinate (column and row, counted in microtiles) into the byte offset of that microtile inside a texture image. A microtile is always 64 bytes, so its pixel footprint depends on the pixel size: 8x8 pixels at 1 byte, 8x4 at 2 bytes, 4x4 at 4 bytes and 2x4 at 8 bytes per pixel. Two layouts are supported. The first is a plain raster grid of microtiles. The second groups microtiles into 1 KiB subtiles (4x4 microtiles in raster order) and subtiles into 4 KiB tiles (2x2 subtiles). Tile rows alternate direction, and the order of the four subtiles inside a tile depends on whether the tile row is even or odd.

A request carries the coordinate, the image width in microtiles, the pixel size in bytes and a layout select. The result is registered and appears one cycle later with a valid flag, or with an error flag when the request cannot be addressed. A separate combinational output reports which layout an image of a given pixel width and height must use.

Top module: `tile_addr_gen`

## Requirements
- R1: The result of a request presented on one rising edge appears on the outputs after that edge and holds for one cycle; a cycle without a request leaves out_valid and out_err low and out_offset zero on the next cycle. out_valid and out_err are never both high.
- R2: With req_tiled low (raster layout), the offset is 64 x (req_uy x req_stride + req_ux).
- R3: With req_tiled high, tiles are 4096 bytes; with n = req_stride/8, tile row ty = req_uy/8 and tile column tx = req_ux/8, the tile lies at 4096 x (ty x n + c), where c = tx on even ty and c = n - 1 - tx on odd ty.
- R4: On even tile rows, with row 0 at the bottom, the four 1 KiB subtiles of a tile sit in memory in the order bottom-left, top-left, top-right, bottom-right; bit 2 of req_ux selects right, bit 2 of req_uy selects top.
- R5: On odd tile rows the subtile order is top-right, bottom-right, bottom-left, top-left.
- R6: Inside a subtile, a microtile adds 64 x ((req_uy mod 4) x 4 + (req_ux mod 4)).
- R7: A pixel size req_bpp other than 1, 2, 4 or 8 gives out_err high, out_valid low and out_offset zero, in either layout.
- R8: In the tiled layout a req_stride that is not a multiple of 8 gives the same error response; in the raster layout any stride is accepted.
- R9: lay_raster is high when the pixel size is supported and img_w is at most 4 microtile widths or img_h is at most 4 microtile heights (microtile size per pixel size as in the description); it is low otherwise, and low for unsupported pixel sizes.
- R10: While rst_n is low, out_valid, out_err and out_offset are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_tiled | input | 1 | Layout select: 0 raster, 1 tiled |
| req_bpp | input | 4 | Bytes per pixel |
| req_ux | input | CW | Microtile column |
| req_uy | input | CW | Microtile row |
| req_stride | input | SW | Image width in microtiles |
| img_w | input | DW | Image width in pixels for the layout query |
| img_h | input | DW | Image height in pixels for the layout query |
| lay_raster | output | 1 | Image must use the raster layout |
| out_valid | output | 1 | Offset is valid |
| out_err | output | 1 | Request rejected |
| out_offset | output | OW | Byte offset of the microtile |

## Verification
The assertions take for granted that every input is a known value on each rising edge while reset is released, and that the offset fits in OW bits; they do not assume coordinates lie inside the image. The stimulus drives all inputs on the falling edge, keeps coordinates below the stride and 64 rows so no offset overflows, and mixes legal pixel sizes and strides with deliberately illegal ones so both error paths and both tile-row parities are reached.

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int CW = 12,
  parameter int SW = 12,
  parameter int DW = 16,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_tiled,
  input  logic [3:0]    req_bpp,
  input  logic [CW-1:0] req_ux,
  input  logic [CW-1:0] req_uy,
  input  logic [SW-1:0] req_stride,
  input  logic [DW-1:0] img_w,
  input  logic [DW-1:0] img_h,
  output logic          lay_raster,
  output logic          out_valid,
  output logic          out_err,
  output logic [OW-1:0] out_offset
);

  localparam int TW = SW - 3;

  logic          bpp_ok, stride_ok;
  logic [OW-1:0] raster_off, tiled_off, tile_idx, eff_tx;
  logic [TW-1:0] tstride;
  logic [CW-4:0] tx, ty;
  logic [1:0]    slot;
  logic [3:0]    uw, uh;

  assign bpp_ok    = (req_bpp == 4'd1) || (req_bpp == 4'd2) || (req_bpp == 4'd4) || (req_bpp == 4'd8);
  assign stride_ok = !req_tiled || (req_stride[2:0] == 3'b000);

  assign raster_off = (OW'(req_uy) * OW'(req_stride) + OW'(req_ux)) << 6;

  assign tstride  = req_stride[SW-1:3];
  assign tx       = req_ux[CW-1:3];
  assign ty       = req_uy[CW-1:3];
  assign eff_tx   = ty[0] ? (OW'(tstride) - OW'(tx) - OW'(1)) : OW'(tx);
  assign tile_idx = OW'(ty) * OW'(tstride) + eff_tx;

  always_comb begin
    case ({ty[0], req_uy[2], req_ux[2]})
      3'b000:  slot = 2'd0;
      3'b001:  slot = 2'd3;
      3'b010:  slot = 2'd1;
      3'b011:  slot = 2'd2;
      3'b100:  slot = 2'd2;
      3'b101:  slot = 2'd1;
      3'b110:  slot = 2'd3;
      default: slot = 2'd0;
    endcase
  end

  assign tiled_off = (tile_idx << 12) + (OW'(slot) << 10) + (OW'({req_uy[1:0], req_ux[1:0]}) << 6);

  always_comb begin
    case (req_bpp)
      4'd1:    begin uw = 4'd8; uh = 4'd8; end
      4'd2:    begin uw = 4'd8; uh = 4'd4; end
      4'd4:    begin uw = 4'd4; uh = 4'd4; end
      4'd8:    begin uw = 4'd2; uh = 4'd4; end
      default: begin uw = 4'd0; uh = 4'd0; end
    endcase
  end

  assign lay_raster = bpp_ok && ((img_w <= DW'({uw, 2'b00})) || (img_h <= DW'({uh, 2'b00})));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_offset <= '0;
    end else begin
      out_valid  <= req_valid && bpp_ok && stride_ok;
      out_err    <= req_valid && !(bpp_ok && stride_ok);
      out_offset <= (req_valid && bpp_ok && stride_ok) ? (req_tiled ? tiled_off : raster_off) : '0;
    end
  end

  p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_err && out_offset == '0));

  p_bad_bpp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_bpp inside {4'd1, 4'd2, 4'd4, 4'd8})) |=> (out_err && out_offset == '0));

  p_bad_stride_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_tiled && req_stride[2:0] != 3'b000) |=> out_err);

  p_raster_any_stride_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_tiled && req_bpp == 4'd4) |=> out_valid);

  p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_offset[5:0] == 6'd0));

  p_reset_state_r10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_err && out_offset == '0));

endmodule

// File: tb/tb_tile_addr_gen.sv
module tb_tile_addr_gen;
  localparam int CW = 12, SW = 12, DW = 16, OW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_tiled = 1'b0;
  logic [3:0] req_bpp = 4'd4;
  logic [CW-1:0] req_ux = '0, req_uy = '0;
  logic [SW-1:0] req_stride = 12'd8;
  logic [DW-1:0] img_w = '0, img_h = '0;
  logic lay_raster, out_valid, out_err;
  logic [OW-1:0] out_offset;

  int compared = 0, mismatched = 0, cycles = 0;
  logic exp_v = 1'b0, exp_e = 1'b0;
  longint exp_off = 0;
  string exp_tag = "R10";

  always #10 clk = ~clk;

  tile_addr_gen #(.CW(CW), .SW(SW), .DW(DW), .OW(OW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tiled(req_tiled),
    .req_bpp(req_bpp), .req_ux(req_ux), .req_uy(req_uy), .req_stride(req_stride),
    .img_w(img_w), .img_h(img_h), .lay_raster(lay_raster),
    .out_valid(out_valid), .out_err(out_err), .out_offset(out_offset));

  function automatic bit good_bpp(int b);
    return b == 1 || b == 2 || b == 4 || b == 8;
  endfunction

  function automatic longint tiled_model(int ux, int uy, int stride);
    int n, row, col, right, top, q;
    n = stride / 8;
    row = uy / 8;
    col = (row % 2 == 1) ? (n - 1 - ux / 8) : (ux / 8);
    right = (ux / 4) % 2;
    top = (uy / 4) % 2;
    if (row % 2 == 0) q = right ? (top ? 2 : 3) : (top ? 1 : 0);
    else              q = right ? (top ? 0 : 1) : (top ? 3 : 2);
    return 64'(4096) * (row * n + col) + 1024 * q + 64 * ((uy % 4) * 4 + (ux % 4));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v = 0; exp_e = 0; exp_off = 0; exp_tag = "R10";
    end else if (!req_valid) begin
      exp_v = 0; exp_e = 0; exp_off = 0; exp_tag = "R1";
    end else if (!good_bpp(int'(req_bpp))) begin
      exp_v = 0; exp_e = 1; exp_off = 0; exp_tag = "R7";
    end else if (req_tiled && (req_stride % 8 != 0)) begin
      exp_v = 0; exp_e = 1; exp_off = 0; exp_tag = "R8";
    end else if (!req_tiled) begin
      exp_v = 1; exp_e = 0; exp_tag = "R2";
      exp_off = 64 * (longint'(req_uy) * req_stride + req_ux);
    end else begin
      exp_v = 1; exp_e = 0; exp_tag = "R3 R4 R5 R6";
      exp_off = tiled_model(int'(req_ux), int'(req_uy), int'(req_stride));
    end
  end

  always @(negedge clk) begin
    cycles++;
    compared++;
    if (out_valid !== exp_v || out_err !== exp_e || longint'(out_offset) !== exp_off) begin
      mismatched++;
      $display("FAIL %s: got v=%0b e=%0b off=%0d, expected v=%0b e=%0b off=%0d",
               exp_tag, out_valid, out_err, out_offset, exp_v, exp_e, exp_off);
    end
    if (cycles > 200000) begin
      mismatched++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic send(bit t, int b, int ux, int uy, int s);
    @(negedge clk);
    req_valid = 1; req_tiled = t; req_bpp = 4'(b);
    req_ux = CW'(ux); req_uy = CW'(uy); req_stride = SW'(s);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic lay_check(int b, int w, int h, bit exp);
    @(negedge clk);
    req_valid = 0; req_bpp = 4'(b); img_w = DW'(w); img_h = DW'(h);
    #1;
    compared++;
    if (lay_raster !== exp) begin
      mismatched++;
      $display("FAIL R9: bpp=%0d w=%0d h=%0d got %0b expected %0b", b, w, h, lay_raster, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 raster, non-multiple-of-8 stride accepted (R8)
    send(0, 4, 3, 2, 10);
    send(0, 1, 0, 0, 5);
    idle();
    // R3 R4 even row, all four quadrants
    send(1, 4, 0, 0, 32);
    send(1, 4, 4, 0, 32);
    send(1, 4, 0, 4, 32);
    send(1, 4, 4, 4, 32);
    // R5 odd row: serpentine column and odd quadrant order
    send(1, 2, 0, 8, 32);
    send(1, 2, 4, 8, 32);
    send(1, 2, 0, 12, 32);
    send(1, 2, 12, 12, 32);
    // R6 inner microtile position
    send(1, 8, 27, 19, 32);
    // R7 bad pixel size, R8 bad tiled stride
    send(0, 3, 1, 1, 8);
    send(1, 0, 1, 1, 8);
    send(1, 4, 1, 1, 12);
    idle();
    // R9 layout query
    lay_check(4, 16, 100, 1);
    lay_check(4, 17, 17, 0);
    lay_check(1, 32, 64, 1);
    lay_check(1, 33, 33, 0);
    lay_check(8, 8, 100, 1);
    lay_check(8, 9, 100, 0);
    lay_check(2, 100, 16, 1);
    lay_check(2, 100, 17, 0);
    lay_check(3, 1, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      int s, b, r;
      r = $urandom_range(0, 19);
      s = (r == 0) ? $urandom_range(1, 63) : 8 * $urandom_range(1, 8);
      b = (r == 1) ? $urandom_range(0, 15) : (1 << $urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) idle();
      else send($urandom_range(0, 1), b, $urandom_range(0, s - 1), $urandom_range(0, 63), s);
    end
    idle();
    // R10 reset clears outputs
    send(0, 4, 5, 5, 16);
    @(negedge clk);
    rst_n = 0;
    req_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule